// File: doc/BRIEF.md
# Hierarchical Single-Vector Interrupt Controller

This block gathers interrupt events from up to eight peripheral modules, each carrying a fixed number of sources. It latches each event in a sticky per-source flag. It then filters the flags through three layers of enables: a per-source enable, a per-module mask and one global enable. The result is a single registered trigger pulse toward a processor core. Every entry uses the same programmable vector address. The hardware never picks a winner among sources, so the handler finds and orders them in software.

The core acknowledges an entry with a take pulse, which sets an in-service bit. While that bit is set, the block issues no further triggers. A return pulse from the core clears the bit. Software can also clear it inside a handler to allow a nested entry through the same vector. A read-only module flag register shows which modules currently hold an active source.

The register port is a simple write strobe with address and data, plus a combinational read path. The address map is as follows:
- Address 0: vector register.
- Address 1: control register. Bit 0 is the global enable and bit 1 is the in-service bit.
- Address 2: module mask, one bit per module.
- Address 3: module flags, read-only.
- Addresses 8+m: source flags of module m.
- Addresses 16+m: source enables of module m.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Source s of module m is input bit src_evt[m*SRC_PER_MOD+s] and flag bit s at address 8+m. An event sets that flag on the next clock edge. The flag stays set after the event input falls, until software clears it.
- R2: A write to address 8+m clears every flag bit written as 0 and leaves every bit written as 1 unchanged. If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R3: A source is active only when its flag and its enable bit (address 16+m) are both 1. Bit m of the module flag register (address 3) is the OR of module m's active sources. That register ignores writes and drops as soon as the module's flags are cleared.
- R4: A module's active sources cause a trigger only while bit m of the module mask (address 2) is 1. Setting the mask bit later releases the held request.
- R5: No trigger is issued while the global enable (address 1 bit 0) is 0. Setting the bit releases a held request.
- R6: irq_trig is registered and rises two clock edges after the event input that caused it. It is high for exactly one cycle per entry, and no new pulse is issued until the core pulses irq_take.
- R7: irq_take sets the in-service bit (address 1 bit 1) on the edge where it is sampled, and irq_ret clears it. If both arrive in the same cycle, take wins. All control bits reset to 0.
- R8: While the in-service bit is 1, no trigger is issued and the request stays pending with its flag set. The trigger fires once the bit clears.
- R9: Software writing 0 to the in-service bit inside a handler permits a new (nested) trigger two edges later.
- R10: If a flag is still active at return, a new trigger follows two edges after irq_ret.
- R11: irq_vector always equals the vector register (address 0, reset 0), whichever source caused the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_MOD*SRC_PER_MOD | Per-source event inputs, module-major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data at reg_addr |
| irq_take | input | 1 | Core acknowledges interrupt entry |
| irq_ret | input | 1 | Core returns from interrupt |
| irq_trig | output | 1 | One-cycle interrupt trigger |
| irq_vector | output | VEC_W | Single handler address |

## Verification
A stuck or lost flag shows up as a missing or extra trigger two edges after the event or after the return. It also shows up as a wrong value on the next read of the flag or module-flag register. A wrong in-service state is visible in one of two ways: a trigger appears while the core is still in a handler, or a pending request stays silent after return or after a software clear. The scoreboard compares the exact cycle of every trigger against the cycle predicted from the stimulus, so a delay or a repeated pulse is caught on the cycle it happens.

// File: rtl/irq_tree_pkg.sv
// Shared register map and write-bus type for the interrupt tree.
// Assumes at most eight modules and at most sixteen sources per module.
package irq_tree_pkg;
    localparam int REG_AW         = 5;
    localparam int REG_DW         = 16;
    localparam int MAX_MOD        = 8;
    localparam int ADDR_VEC       = 0;
    localparam int ADDR_CTRL      = 1;
    localparam int ADDR_MASK      = 2;
    localparam int ADDR_MFLAG     = 3;
    localparam int ADDR_FLAG_BASE = 8;
    localparam int ADDR_EN_BASE   = 16;
    localparam int CTRL_GE_BIT    = 0;
    localparam int CTRL_INS_BIT   = 1;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } reg_wr_t;

    // True when the bus carries a write to the given address.
    function automatic logic wr_hit(input reg_wr_t b, input int a);
        return b.wr && (b.addr == REG_AW'(a));
    endfunction
endpackage

// File: rtl/irq_src_bank.sv
// Per-module source bank: sticky flags, source enables and the module's
// active signal. Assumes NSRC <= 16. Event set beats software clear.
module irq_src_bank
    import irq_tree_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int MOD_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  reg_wr_t         bus,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] enables,
    output logic            mod_active
);
    localparam int FLAG_ADDR = ADDR_FLAG_BASE + MOD_IDX;
    localparam int EN_ADDR   = ADDR_EN_BASE + MOD_IDX;

    logic            flag_wr;
    logic            en_wr;
    logic [NSRC-1:0] clr_mask;

    // Decode writes that target this bank.
    always_comb begin
        flag_wr  = wr_hit(bus, FLAG_ADDR);
        en_wr    = wr_hit(bus, EN_ADDR);
        clr_mask = flag_wr ? ~bus.data[NSRC-1:0] : '0;
    end

    // Sticky flags: zero-written bits clear, events set with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | evt;
    end

    // Source enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (en_wr) enables <= bus.data[NSRC-1:0];
    end

    // Module signal: any source with flag and enable both set.
    assign mod_active = |(flags & enables);
endmodule

// File: rtl/irq_csr.sv
// Control registers: vector address, global enable and module mask.
// Assumes NUM_MOD <= 8 and VEC_W <= 16.
module irq_csr
    import irq_tree_pkg::*;
#(
    parameter int NUM_MOD = 8,
    parameter int VEC_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_wr_t            bus,
    output logic [VEC_W-1:0]   vec,
    output logic               ge,
    output logic [NUM_MOD-1:0] mask
);
    // Vector register, one value for every entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     vec <= '0;
        else if (wr_hit(bus, ADDR_VEC)) vec <= bus.data[VEC_W-1:0];
    end

    // Global enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ge <= 1'b0;
        else if (wr_hit(bus, ADDR_CTRL)) ge <= bus.data[CTRL_GE_BIT];
    end

    // Module mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mask <= '0;
        else if (wr_hit(bus, ADDR_MASK)) mask <= bus.data[NUM_MOD-1:0];
    end
endmodule

// File: rtl/irq_trig_unit.sv
// Trigger generation and in-service tracking. Emits one registered pulse
// per entry, then waits for the core's take before it may fire again.
// Precedence for in-service: take, then return, then software write.
module irq_trig_unit
    import irq_tree_pkg::*;
#(
    parameter int NUM_MOD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MOD-1:0] mod_active,
    input  logic [NUM_MOD-1:0] mask,
    input  logic               ge,
    input  logic               take,
    input  logic               ret,
    input  reg_wr_t            bus,
    output logic               trig,
    output logic               ins
);
    logic any_req;
    logic fire;
    logic wait_q;
    logic ins_wr;

    // Combine masked modules with the global and in-service gates.
    always_comb begin
        any_req = |(mod_active & mask);
        fire    = ge && !ins && any_req && !wait_q;
        ins_wr  = wr_hit(bus, ADDR_CTRL);
    end

    // Registered trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= fire;
    end

    // Hold off further pulses between a trigger and its take.
    always_ff @(posedge clk) begin
        if (!rst_n)    wait_q <= 1'b0;
        else if (take) wait_q <= 1'b0;
        else if (fire) wait_q <= 1'b1;
    end

    // In-service bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ins <= 1'b0;
        else if (take)   ins <= 1'b1;
        else if (ret)    ins <= 1'b0;
        else if (ins_wr) ins <= bus.data[CTRL_INS_BIT];
    end
endmodule

// File: rtl/irq_tree_ctrl.sv
// Top of the hierarchical single-vector interrupt controller. Instantiates
// one source bank per module, the control registers and the trigger unit,
// and provides the combinational register read path.
module irq_tree_ctrl
    import irq_tree_pkg::*;
#(
    parameter int NUM_MOD     = 8,
    parameter int SRC_PER_MOD = 4,
    parameter int VEC_W       = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_MOD*SRC_PER_MOD-1:0] src_evt,
    input  logic                           reg_wr,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [REG_DW-1:0]              reg_wdata,
    output logic [REG_DW-1:0]              reg_rdata,
    input  logic                           irq_take,
    input  logic                           irq_ret,
    output logic                           irq_trig,
    output logic [VEC_W-1:0]               irq_vector
);
    localparam int NSRC_TOT = NUM_MOD * SRC_PER_MOD;

    reg_wr_t                               bus;
    logic [NUM_MOD-1:0][SRC_PER_MOD-1:0]  flag_arr;
    logic [NUM_MOD-1:0][SRC_PER_MOD-1:0]  en_arr;
    logic [NUM_MOD-1:0]                   mod_active;
    logic [NUM_MOD-1:0]                   mask_bits;
    logic [NSRC_TOT-1:0]                  flag_vec;
    logic                                 ge_bit;
    logic                                 ins_bit;

    // Bundle the write port.
    always_comb begin
        bus.wr   = reg_wr;
        bus.addr = reg_addr;
        bus.data = reg_wdata;
    end

    for (genvar m = 0; m < NUM_MOD; m++) begin : g_bank
        irq_src_bank #(
            .NSRC    (SRC_PER_MOD),
            .MOD_IDX (m)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (src_evt[m*SRC_PER_MOD +: SRC_PER_MOD]),
            .bus        (bus),
            .flags      (flag_arr[m]),
            .enables    (en_arr[m]),
            .mod_active (mod_active[m])
        );
        assign flag_vec[m*SRC_PER_MOD +: SRC_PER_MOD] = flag_arr[m];
    end

    irq_csr #(
        .NUM_MOD (NUM_MOD),
        .VEC_W   (VEC_W)
    ) u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (bus),
        .vec   (irq_vector),
        .ge    (ge_bit),
        .mask  (mask_bits)
    );

    irq_trig_unit #(
        .NUM_MOD (NUM_MOD)
    ) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_active (mod_active),
        .mask       (mask_bits),
        .ge         (ge_bit),
        .take       (irq_take),
        .ret        (irq_ret),
        .bus        (bus),
        .trig       (irq_trig),
        .ins        (ins_bit)
    );

    // Read multiplexer over the register map.
    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            ADDR_VEC:   reg_rdata[VEC_W-1:0] = irq_vector;
            ADDR_CTRL: begin
                reg_rdata[CTRL_GE_BIT]  = ge_bit;
                reg_rdata[CTRL_INS_BIT] = ins_bit;
            end
            ADDR_MASK:  reg_rdata[NUM_MOD-1:0] = mask_bits;
            ADDR_MFLAG: reg_rdata[NUM_MOD-1:0] = mod_active;
            default: begin
                for (int m = 0; m < NUM_MOD; m++) begin
                    if (int'(reg_addr) == ADDR_FLAG_BASE + m)
                        reg_rdata[SRC_PER_MOD-1:0] = flag_arr[m];
                    if (int'(reg_addr) == ADDR_EN_BASE + m)
                        reg_rdata[SRC_PER_MOD-1:0] = en_arr[m];
                end
            end
        endcase
    end
endmodule

// File: rtl/irq_tree_ctrl_chk.sv
// Assertion checker for irq_tree_ctrl, attached by bind below. Observes
// ports and the internal flag, enable and in-service state.
module irq_tree_ctrl_chk
    import irq_tree_pkg::*;
#(
    parameter int NUM_MOD     = 8,
    parameter int SRC_PER_MOD = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_MOD*SRC_PER_MOD-1:0] src_evt,
    input logic                           reg_wr,
    input logic [REG_AW-1:0]              reg_addr,
    input logic                           irq_take,
    input logic                           irq_trig,
    input logic                           ins_bit,
    input logic                           ge_bit,
    input logic [NUM_MOD-1:0]             mask_bits,
    input logic [NUM_MOD-1:0]             mod_active,
    input logic [NUM_MOD*SRC_PER_MOD-1:0] flag_vec
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trig |=> !irq_trig);

    a_r8_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        ins_bit |=> !irq_trig);

    a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ge_bit |=> !irq_trig);

    a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_bits & mod_active) == '0) |=> !irq_trig);

    a_r7_take_sets_ins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> ins_bit);

    for (genvar i = 0; i < NUM_MOD*SRC_PER_MOD; i++) begin : g_flag
        localparam int FADDR = ADDR_FLAG_BASE + i / SRC_PER_MOD;
        // R1 and R2: an event always leaves the flag set.
        a_r1_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> flag_vec[i]);
        // R1: without a write to its register a set flag stays set.
        a_r1_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[i] && !(reg_wr && reg_addr == REG_AW'(FADDR))) |=> flag_vec[i]);
    end
endmodule

bind irq_tree_ctrl irq_tree_ctrl_chk #(
    .NUM_MOD     (NUM_MOD),
    .SRC_PER_MOD (SRC_PER_MOD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .irq_take   (irq_take),
    .irq_trig   (irq_trig),
    .ins_bit    (ins_bit),
    .ge_bit     (ge_bit),
    .mask_bits  (mask_bits),
    .mod_active (mod_active),
    .flag_vec   (flag_vec)
);

// File: tb/test_irq_tree_ctrl.sv
// Scoreboard bench: drivers queue the cycle at which a trigger is due,
// a monitor pops and compares each trigger and acts as the core's take.
module test_irq_tree_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NM  = 8;
    localparam int NS  = 4;
    localparam int VW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NM*NS-1:0] src_evt = '0;
    logic            reg_wr = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            irq_take = 1'b0;
    logic            irq_ret = 1'b0;
    logic            irq_trig;
    logic [VW-1:0]   irq_vector;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_q[$];

    irq_tree_ctrl #(.NUM_MOD(NM), .SRC_PER_MOD(NS), .VEC_W(VW)) i_irq_tree_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_take(irq_take), .irq_ret(irq_ret), .irq_trig(irq_trig),
        .irq_vector(irq_vector));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each trigger with the scoreboard, then take it.
    always @(negedge clk) begin
        int e;
        if (rst_n && irq_trig) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected trigger at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check("R6 trigger cycle", cyc, e);
            end
            irq_take = 1'b1;
        end else begin
            irq_take = 1'b0;
        end
    end

    task automatic reg_write(input int a, input int d, input bit exp);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 16'(d);
        if (exp) exp_q.push_back(cyc + 2);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
        check(tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse_evt(input int idx, input bit exp);
        @(negedge clk);
        src_evt[idx] = 1'b1;
        if (exp) exp_q.push_back(cyc + 2);
        @(negedge clk);
        src_evt[idx] = 1'b0;
    endtask

    task automatic do_ret(input bit exp);
        @(negedge clk);
        irq_ret = 1'b1;
        if (exp) exp_q.push_back(cyc + 2);
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        check(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        reg_read(0, 0, "R11 vector reset");
        reg_read(1, 0, "R7 control reset");
        reg_read(2, 0, "R4 mask reset");
        reg_read(3, 0, "R3 module flags reset");
        reg_read(8, 0, "R1 flags reset");
        check("R6 trigger low after reset", int'(irq_trig), 0);

        // Basic entry through module 2 source 1
        reg_write(0, 16'h1234, 0);
        check("R11 vector output", int'(irq_vector), 16'h1234);
        reg_write(18, 2, 0);
        reg_write(2, 8'h04, 0);
        reg_write(1, 1, 0);
        pulse_evt(2*NS+1, 1);
        settle("R6 basic trigger");
        reg_read(1, 3, "R7 take sets in-service");
        reg_read(10, 2, "R1 flag sticky after event");
        reg_read(3, 8'h04, "R3 module flag");
        reg_write(3, 0, 0);
        reg_read(3, 8'h04, "R3 module flags ignore writes");
        reg_write(10, 16'hFFFF, 0);
        reg_read(10, 2, "R2 write one keeps flag");
        check("R11 vector same after entry", int'(irq_vector), 16'h1234);

        // Return without clearing retriggers
        do_ret(1);
        settle("R10 retrigger after return");
        reg_read(1, 3, "R10 re-entered");
        reg_write(10, 16'hFFFD, 0);
        reg_read(10, 0, "R2 write zero clears");
        reg_read(3, 0, "R3 module flag drops");
        do_ret(0);
        settle("R7 clean return");
        reg_read(1, 1, "R7 return clears in-service");

        // Pending while in service
        reg_write(1, 3, 0);
        pulse_evt(2*NS+1, 0);
        settle("R8 no trigger while in service");
        reg_read(10, 2, "R8 flag pending");
        do_ret(1);
        settle("R8 pending fires after clear");
        reg_write(10, 0, 0);
        do_ret(0);
        settle("R8 cleanup");

        // Nested entry by software clearing in-service
        pulse_evt(2*NS+1, 1);
        settle("R9 first entry");
        reg_write(21, 8, 0);
        reg_write(2, 8'h24, 0);
        pulse_evt(5*NS+3, 0);
        settle("R9 held in handler");
        reg_read(3, 8'h24, "R3 two modules active");
        reg_write(1, 1, 1);
        settle("R9 nested trigger");
        reg_write(10, 0, 0);
        reg_write(13, 0, 0);
        do_ret(0);
        settle("R9 cleanup");

        // Module mask gating
        reg_write(19, 1, 0);
        pulse_evt(3*NS+0, 0);
        settle("R4 masked module silent");
        reg_read(3, 8'h08, "R3 module flag ignores mask");
        reg_write(2, 8'h2C, 1);
        settle("R4 unmask releases request");
        reg_write(11, 0, 0);
        do_ret(0);
        settle("R4 cleanup");

        // Global enable gating
        reg_write(1, 0, 0);
        pulse_evt(3*NS+0, 0);
        settle("R5 global disable silent");
        reg_write(1, 1, 1);
        settle("R5 global enable releases request");
        reg_write(11, 0, 0);
        do_ret(0);
        settle("R5 cleanup");

        // Source enable gating
        pulse_evt(3*NS+2, 0);
        settle("R3 disabled source silent");
        reg_read(11, 4, "R1 flag set on disabled source");
        reg_read(3, 0, "R3 disabled source not active");
        reg_write(19, 5, 1);
        settle("R3 enable releases request");
        reg_write(11, 0, 0);
        do_ret(0);
        settle("R3 cleanup");

        // Set beats clear in the same cycle
        @(negedge clk);
        src_evt[3*NS+0] = 1'b1;
        reg_wr = 1'b1; reg_addr = 5'd11; reg_wdata = 16'h0000;
        exp_q.push_back(cyc + 2);
        @(negedge clk);
        src_evt[3*NS+0] = 1'b0;
        reg_wr = 1'b0;
        settle("R2 set wins trigger");
        reg_read(11, 1, "R2 set wins over clear");
        reg_write(11, 0, 0);
        do_ret(0);
        settle("R2 cleanup");

        finish_run();
    end
endmodule